// File: doc/BRIEF.md
# Even Parity Generator and Checker for a Multiplexed Bus

This block looks after data integrity on a 32-bit multiplexed address/data bus that also carries four command/byte-enable lines. On the driving side it takes the 36 bits the agent puts on the bus in a clock and produces the even parity bit one clock later. The parity bit therefore trails the value it covers by one cycle, as the bus timing requires.

On the receiving side it takes each sampled phase together with a valid strobe and two flags. One flag marks an address phase and the other marks a special cycle. The block takes the parity bit one clock after that phase and compares it with parity it recomputes from the stored phase. A mismatch is reported on one of two active-low outputs. A normal data phase goes to the parity-error output. A special-cycle data phase, or any address phase, goes to the system-error output. An enable input gates both outputs. The outputs are modelled as plain levels, so the open-drain drive stays outside the block.

Top module: `bus_parity_unit`

## Requirements
- R1: When `drv_valid` is high at a clock edge, `par_oe` is high for the next cycle only and `par_out` then equals the XOR of all 32 bits of `drv_ad` and all 4 bits of `drv_cbe` from that edge. The 37 bits together then hold an even number of ones.
- R2: While reset is held and right after it, `perr_n` and `serr_n` are high and `par_oe` is low.
- R3: A data phase taken at edge T with `rx_addr`=0 and `rx_special`=0, whose `rx_par` taken at edge T+1 does not give even parity, drives `perr_n` low in the cycle that follows edge T+2.
- R4: The same mismatch on a data phase with `rx_special`=1 drives `serr_n` low, in the same cycle, and leaves `perr_n` high.
- R5: A mismatch on a phase with `rx_addr`=1 drives `serr_n` low and leaves `perr_n` high, whatever `rx_special` is.
- R6: When the parity is correct, neither output goes low.
- R7: When `err_en` is low at edge T+2, both outputs stay high for that phase.
- R8: Each error output stays low for exactly one cycle per faulty phase. Phases on consecutive clocks are judged independently, and each report appears three edges after its own phase.
- R9: `perr_n` and `serr_n` are never low in the same cycle.
- R10: Only the `rx_par` value at edge T+1 counts for the phase taken at edge T. Its value at edge T and at edge T+2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_valid | input | 1 | The agent drives `drv_ad`/`drv_cbe` this clock |
| drv_ad | input | 32 | Address/data value being driven |
| drv_cbe | input | 4 | Command/byte-enable value being driven |
| par_out | output | 1 | Generated even parity bit, one clock late |
| par_oe | output | 1 | `par_out` is to be driven this cycle |
| rx_valid | input | 1 | A bus phase is sampled this clock |
| rx_addr | input | 1 | The sampled phase is an address phase |
| rx_special | input | 1 | The sampled phase belongs to a special cycle |
| rx_ad | input | 32 | Sampled address/data lines |
| rx_cbe | input | 4 | Sampled command/byte-enable lines |
| rx_par | input | 1 | Sampled parity line (covers the previous phase) |
| err_en | input | 1 | Error reporting enable |
| perr_n | output | 1 | Active-low parity error, normal data phases |
| serr_n | output | 1 | Active-low system error, address and special phases |

## Verification
Suppose the phase-to-parity pairing is off by one stage. The report then follows a good phase instead of a bad one, or it lands one cycle early or late, and the exact-cycle checks on back-to-back phases show this within four clocks. A bad cycle-type route shows as the wrong output going low for a special or address phase. A stuck error stage shows as a pulse held past one cycle. A fault in the parity tree shows at once on `par_out` for a single-bit pattern in either bus field.

// File: rtl/pbx_pkg.sv
package pbx_pkg;

  localparam int unsigned AD_BITS  = 32;
  localparam int unsigned CBE_BITS = 4;

  typedef enum logic {
    ROUTE_PERR = 1'b0,
    ROUTE_SERR = 1'b1
  } route_e;

  // Address phases and special cycles report on the system-error line.
  function automatic route_e pick_route(input logic is_addr, input logic is_special);
    return (is_addr || is_special) ? ROUTE_SERR : ROUTE_PERR;
  endfunction

  // Odd sum over the covered bits plus the received bit breaks even parity.
  function automatic logic parity_miss(input logic odd_sum, input logic par_bit);
    return odd_sum ^ par_bit;
  endfunction

endpackage

// File: rtl/pbx_par_calc.sv
module pbx_par_calc #(
  parameter int unsigned W = 36
) (
  input  logic [W-1:0] vec,
  output logic         odd
);

  logic [W-1:0] chain;

  assign chain[0] = vec[0];

  generate
    for (genvar i = 1; i < W; i++) begin : g_fold
      assign chain[i] = chain[i-1] ^ vec[i];
    end
  endgenerate

  assign odd = chain[W-1];

endmodule

// File: rtl/pbx_par_gen.sv
module pbx_par_gen #(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_valid,
  input  logic [AD_W-1:0]  drv_ad,
  input  logic [CBE_W-1:0] drv_cbe,
  output logic             par_q,
  output logic             oe_q
);

  localparam int unsigned SUM_W = AD_W + CBE_W;

  logic sum_odd;

  pbx_par_calc #(.W(SUM_W)) u_calc (
    .vec (({drv_cbe, drv_ad})),
    .odd (sum_odd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= sum_odd;
      oe_q  <= drv_valid;
    end
  end

endmodule

// File: rtl/pbx_par_chk.sv
module pbx_par_chk
  import pbx_pkg::*;
#(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_addr,
  input  logic             rx_special,
  input  logic [AD_W-1:0]  rx_ad,
  input  logic [CBE_W-1:0] rx_cbe,
  input  logic             rx_par,
  input  logic             err_en,
  output logic             fault_q,
  output route_e           route_q,
  output logic             perr_q,
  output logic             serr_q
);

  localparam int unsigned SUM_W = AD_W + CBE_W;

  logic   rx_odd;
  logic   held_vld;
  logic   held_odd;
  route_e held_route;

  pbx_par_calc #(.W(SUM_W)) u_calc (
    .vec (({rx_cbe, rx_ad})),
    .odd (rx_odd)
  );

  // Stage 1: keep the phase until its parity bit arrives.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_vld   <= 1'b0;
      held_odd   <= 1'b0;
      held_route <= ROUTE_PERR;
    end else begin
      held_vld   <= rx_valid;
      held_odd   <= rx_odd;
      held_route <= pick_route(rx_addr, rx_special);
    end
  end

  // Stage 2: compare with the late parity bit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      route_q <= ROUTE_PERR;
    end else begin
      fault_q <= held_vld && parity_miss(held_odd, rx_par);
      route_q <= held_route;
    end
  end

  // Stage 3: one-cycle report on the chosen line.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perr_q <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      perr_q <= fault_q && err_en && (route_q == ROUTE_PERR);
      serr_q <= fault_q && err_en && (route_q == ROUTE_SERR);
    end
  end

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import pbx_pkg::*;
#(
  parameter int unsigned AD_W  = AD_BITS,
  parameter int unsigned CBE_W = CBE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drv_valid,
  input  logic [AD_W-1:0]  drv_ad,
  input  logic [CBE_W-1:0] drv_cbe,
  output logic             par_out,
  output logic             par_oe,
  input  logic             rx_valid,
  input  logic             rx_addr,
  input  logic             rx_special,
  input  logic [AD_W-1:0]  rx_ad,
  input  logic [CBE_W-1:0] rx_cbe,
  input  logic             rx_par,
  input  logic             err_en,
  output logic             perr_n,
  output logic             serr_n
);

  // Named internal events, visible to the bound checker.
  logic   chk_fault;
  route_e chk_route;
  logic   perr_evt;
  logic   serr_evt;

  pbx_par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_valid (drv_valid),
    .drv_ad    (drv_ad),
    .drv_cbe   (drv_cbe),
    .par_q     (par_out),
    .oe_q      (par_oe)
  );

  pbx_par_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_addr    (rx_addr),
    .rx_special (rx_special),
    .rx_ad      (rx_ad),
    .rx_cbe     (rx_cbe),
    .rx_par     (rx_par),
    .err_en     (err_en),
    .fault_q    (chk_fault),
    .route_q    (chk_route),
    .perr_q     (perr_evt),
    .serr_q     (serr_evt)
  );

  assign perr_n = ~perr_evt;
  assign serr_n = ~serr_evt;

endmodule

// File: rtl/bus_parity_unit_sva.sv
module bus_parity_unit_sva
  import pbx_pkg::*;
#(
  parameter int unsigned AD_W  = 32,
  parameter int unsigned CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             drv_valid,
  input logic [AD_W-1:0]  drv_ad,
  input logic [CBE_W-1:0] drv_cbe,
  input logic             par_out,
  input logic             par_oe,
  input logic             rx_valid,
  input logic             rx_addr,
  input logic             rx_special,
  input logic [AD_W-1:0]  rx_ad,
  input logic [CBE_W-1:0] rx_cbe,
  input logic             rx_par,
  input logic             err_en,
  input logic             perr_n,
  input logic             serr_n,
  input logic             chk_fault,
  input route_e           chk_route
);

  // R1: driven parity makes the 37 bits even.
  a_r1_even_drive: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe |-> ((^{$past(drv_cbe), $past(drv_ad)}) == par_out));

  // R1: output enable follows the drive strobe by one clock.
  a_r1_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drv_valid) |-> par_oe);

  // R9: one fault never reaches both lines.
  a_r9_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(!perr_n && !serr_n));

  // R3: a parity-error report needs a normal data phase three edges back.
  a_r3_perr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> ($past(rx_valid, 3) && !$past(rx_addr, 3) && !$past(rx_special, 3)));

  // R4/R5: a system-error report needs a bad parity bit two edges back.
  a_r5_serr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !serr_n |-> ($past(rx_valid, 3) && ($past(rx_addr, 3) || $past(rx_special, 3))
                 && ((^{$past(rx_cbe, 3), $past(rx_ad, 3)}) != $past(rx_par, 2))));

  // R7: a report needs reporting enabled at its own edge.
  a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n || !serr_n) |-> ($past(err_en) && $past(chk_fault)));

endmodule

bind bus_parity_unit bus_parity_unit_sva #(.AD_W(AD_W), .CBE_W(CBE_W)) u_sva (.*);

// File: tb/bus_parity_unit_bench.sv
module bus_parity_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        drv_valid = 1'b0;
  logic [31:0] drv_ad = '0;
  logic [3:0]  drv_cbe = '0;
  logic        par_out, par_oe;
  logic        rx_valid = 1'b0, rx_addr = 1'b0, rx_special = 1'b0;
  logic [31:0] rx_ad = '0;
  logic [3:0]  rx_cbe = '0;
  logic        rx_par = 1'b0;
  logic        err_en = 1'b1;
  logic        perr_n, serr_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bus_parity_unit u_bus_parity_unit (.*);

  // Bench model: count the ones, keep the lowest bit.
  function automatic logic want_par(input logic [31:0] ad, input logic [3:0] cbe);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += ad[i];
    for (int i = 0; i < 4; i++)  ones += cbe[i];
    return logic'(ones % 2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_lines(input string req, input logic p, input logic s);
    check({req, " perr_n"}, {31'b0, perr_n}, {31'b0, p});
    check({req, " serr_n"}, {31'b0, serr_n}, {31'b0, s});
  endtask

  // R1 scenario: drive one value, check the late parity bit.
  task automatic drive_case(input logic [31:0] ad, input logic [3:0] cbe);
    @(negedge clk);
    drv_valid = 1'b1; drv_ad = ad; drv_cbe = cbe;
    @(negedge clk);
    drv_valid = 1'b0; drv_ad = ~ad; drv_cbe = ~cbe;
    check("R1 par_oe", {31'b0, par_oe}, 32'd1);
    check("R1 par_out", {31'b0, par_out}, {31'b0, want_par(ad, cbe)});
    @(negedge clk);
    check("R1 par_oe drop", {31'b0, par_oe}, 32'd0);
  endtask

  // R3..R8, R10 scenario: one received phase, outputs checked cycle by cycle.
  task automatic rx_case(input string req, input logic [31:0] ad, input logic [3:0] cbe,
                         input logic is_addr, input logic is_spec, input logic flip,
                         input logic en);
    logic sent, hit;
    sent = want_par(ad, cbe) ^ flip;
    hit  = flip && en;
    @(negedge clk);
    rx_valid = 1'b1; rx_addr = is_addr; rx_special = is_spec;
    rx_ad = ad; rx_cbe = cbe; rx_par = ~sent;   // R10: wrong bit at edge T
    @(negedge clk);
    rx_valid = 1'b0; rx_addr = 1'b0; rx_special = 1'b0;
    rx_ad = ~ad; rx_cbe = ~cbe; rx_par = sent;
    @(negedge clk);
    rx_par = ~sent;                              // R10: wrong bit at edge T+2
    err_en = en;
    check_lines({req, " early"}, 1'b1, 1'b1);
    @(negedge clk);
    err_en = 1'b1;
    check_lines(req, !(hit && !(is_addr || is_spec)), !(hit && (is_addr || is_spec)));
    @(negedge clk);
    check_lines({req, " R8 hold"}, 1'b1, 1'b1);
  endtask

  // R8 scenario: three phases on consecutive clocks.
  task automatic back_to_back();
    logic [31:0] a0, a1, a2;
    a0 = 32'h1234_5678; a1 = 32'hFFFF_0000; a2 = 32'h0000_0001;
    @(negedge clk);
    rx_valid = 1'b1; rx_addr = 1'b0; rx_special = 1'b0; rx_ad = a0; rx_cbe = 4'h3;
    @(negedge clk);
    rx_par = ~want_par(a0, 4'h3);                // bad, normal
    rx_ad = a1; rx_cbe = 4'hC;
    @(negedge clk);
    rx_par = want_par(a1, 4'hC);                 // good
    rx_special = 1'b1; rx_ad = a2; rx_cbe = 4'h0;
    @(negedge clk);
    rx_par = ~want_par(a2, 4'h0);                // bad, special
    rx_valid = 1'b0; rx_special = 1'b0;
    check_lines("R8 first phase", 1'b0, 1'b1);
    @(negedge clk);
    check_lines("R8 second phase", 1'b1, 1'b1);
    @(negedge clk);
    check_lines("R8 third phase", 1'b1, 1'b0);
    @(negedge clk);
    check_lines("R8 quiet", 1'b1, 1'b1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R2: outputs during reset
    check("R2 perr_n in reset", {31'b0, perr_n}, 32'd1);
    check("R2 serr_n in reset", {31'b0, serr_n}, 32'd1);
    check("R2 par_oe in reset", {31'b0, par_oe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 par_oe after reset", {31'b0, par_oe}, 32'd0);
    check_lines("R2 after reset", 1'b1, 1'b1);

    drive_case(32'h0000_0000, 4'h0);
    drive_case(32'h0000_0001, 4'h0);
    drive_case(32'h0000_0000, 4'h8);
    drive_case(32'hFFFF_FFFF, 4'hF);
    drive_case(32'h8000_0000, 4'hF);
    drive_case(32'hA5C3_0F71, 4'h6);

    rx_case("R3 normal bad",         32'hDEAD_BEEF, 4'h7, 1'b0, 1'b0, 1'b1, 1'b1);
    rx_case("R4 special bad",        32'h0F0F_0F0F, 4'h1, 1'b0, 1'b1, 1'b1, 1'b1);
    rx_case("R5 addr bad",           32'h0000_1000, 4'h6, 1'b1, 1'b0, 1'b1, 1'b1);
    rx_case("R5 addr special bad",   32'h7FFF_FFFF, 4'h2, 1'b1, 1'b1, 1'b1, 1'b1);
    rx_case("R6 normal good",        32'hCAFE_F00D, 4'hA, 1'b0, 1'b0, 1'b0, 1'b1);
    rx_case("R6 addr good",          32'h1111_1111, 4'hE, 1'b1, 1'b0, 1'b0, 1'b1);
    rx_case("R7 normal masked",      32'h5555_AAAA, 4'h5, 1'b0, 1'b0, 1'b1, 1'b0);
    rx_case("R7 addr masked",        32'h0000_0003, 4'h9, 1'b1, 1'b0, 1'b1, 1'b0);
    rx_case("R10 zero word good",    32'h0000_0000, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    back_to_back();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule